// File: doc/BRIEF.md
# Dual-Overflow Watchdog Timer

This block is a watchdog timer for a peripheral bus. Its register file runs on the bus clock, and its counter runs on a separate, free-running oscillator clock. Software sets up the watchdog in three steps. It writes a 12-bit period value into the top bits of the period register, clears the lapsed-time count, and then sets the enable bit. A 20-bit prescaler divides the oscillator clock, and its wrap advances a 12-bit count. When that count matches the period value, one overflow is complete.

The first overflow raises the watchdog interrupt. If a second overflow follows before software refreshes the timer, the block issues a one-cycle system reset request. Software refreshes the timer by writing 1 to bit 0 of the status register, which restarts the count and clears the interrupt. Configuration writes are carried into the oscillator domain through toggle synchronizers, so software must wait a short settle time after each one.

Two further functions live in the register file. A reset-routing select register takes a per-bit write-enable mask in its upper half, so each routing bit changes only when its mask bit is set. A parity-error input is registered onto its own interrupt output.

Top module: `wdt_dual_ovf`

## Requirements
- R1: After reset, all outputs are low and the registers at 0x00, 0x04, 0x0C and 0x10 read as zero.
- R2: The period register at 0x04 keeps only write data bits [31:20] as the period N. Bits [19:0] always read back as zero.
- R3: The enable bit is bit 0 at 0x00. Once enable has crossed into the oscillator domain, the interrupt rises after (N+1)*2^PRE_W oscillator cycles of counting.
- R4: A second consecutive overflow with no refresh drives the reset request high for exactly one oscillator cycle, (N+1)*2^PRE_W cycles after the interrupt rose. It fires only once until the next module reset.
- R5: A write to 0x0C with bit 0 set clears the pending interrupt and restarts the count from zero. A write to 0x0C with bit 0 clear has no effect.
- R6: Any write to the lapsed-time register at 0x08 restarts the prescaler and the count from zero, which delays the next overflow.
- R7: Clearing the enable bit stops counting and clears the pending interrupt and the first-overflow state, so no reset request follows.
- R8: Bit 0 of the status register at 0x0C reads back the pending interrupt.
- R9: The reset-routing register at 0x10 holds 3 bits in [2:0]. Bit i is updated from wdata[i] only when wdata[16+i] is 1 in the same write.
- R10: The parity-error output follows the parity-error input one bus clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| prst | input | 1 | Synchronous active-high reset, bus domain |
| oclk | input | 1 | Oscillator clock for the counter |
| orst | input | 1 | Synchronous active-high reset, oscillator domain |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data is valid on the next bus clock |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| par_err_i | input | 1 | Parity-error indication |
| wdt_irq_o | output | 1 | Watchdog interrupt (pending after first overflow) |
| perr_irq_o | output | 1 | Parity-error interrupt |
| sys_rst_req_o | output | 1 | One-cycle system reset request, oscillator domain |
| rst_route_o | output | 3 | Reset-routing select bits |

## Verification
The case that is hardest to reach from the ports is a refresh or a lapsed-time clear that lands between the first and second overflow, or just before the first one. It has to arrive after the multi-cycle crossing delay and still ahead of the next prescaler wrap. The bench uses a 2-bit prescaler, so one period lasts only a few dozen oscillator cycles, and it sweeps N across eight values. It schedules each refresh and clear a counted number of oscillator cycles after enable, well inside the window and with margin for the synchronizer latency. The gap between the interrupt and the reset request does not depend on that latency, so the bench checks it exactly.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int DW      = 32;
    localparam int AW      = 5;
    localparam int PER_W   = 12;
    localparam int PER_LSB = DW - PER_W;
    localparam int SEL_W   = 3;
    localparam int SEL_MSK = 16;

    typedef enum logic [AW-1:0] {
        A_CTRL  = 5'h00,
        A_PER   = 5'h04,
        A_LAPSE = 5'h08,
        A_STAT  = 5'h0C,
        A_RSEL  = 5'h10
    } reg_addr_e;

    typedef struct packed {
        logic             en;
        logic [PER_W-1:0] per;
    } cfg_t;

    // index of each toggle in the crossing vector
    localparam int T_CFG   = 0;
    localparam int T_LAPSE = 1;
    localparam int T_KICK  = 2;
    localparam int NTGL    = 3;

    function automatic logic [SEL_W-1:0] masked_upd(input logic [SEL_W-1:0] cur,
                                                    input logic [DW-1:0] wd);
        logic [SEL_W-1:0] r;
        for (int i = 0; i < SEL_W; i++)
            r[i] = wd[SEL_MSK+i] ? wd[i] : cur[i];
        return r;
    endfunction
endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/wdt_bus_regs.sv
module wdt_bus_regs
    import wdt_pkg::*;
(
    input  logic                  pclk,
    input  logic                  prst,
    input  logic                  wr,
    input  logic                  rd,
    input  logic [AW-1:0]         addr,
    input  logic [DW-1:0]         wdata,
    output logic [DW-1:0]         rdata,
    input  logic                  pend_s,
    input  logic                  par_err_i,
    output cfg_t                  cfg_o,
    output logic [NTGL-1:0]       tgl_o,
    output logic [SEL_W-1:0]      route_o,
    output logic                  perr_o
);
    reg_addr_e a;
    assign a = reg_addr_e'(addr);

    cfg_t             cfg_q;
    logic [NTGL-1:0]  tgl_q;
    logic [SEL_W-1:0] sel_q;

    always_ff @(posedge pclk) begin
        if (prst) begin
            cfg_q  <= '0;
            tgl_q  <= '0;
            sel_q  <= '0;
            perr_o <= 1'b0;
        end else begin
            perr_o <= par_err_i;
            if (wr) begin
                case (a)
                    A_CTRL: begin
                        cfg_q.en      <= wdata[0];
                        tgl_q[T_CFG]  <= ~tgl_q[T_CFG];
                    end
                    A_PER: begin
                        cfg_q.per     <= wdata[DW-1:PER_LSB];
                        tgl_q[T_CFG]  <= ~tgl_q[T_CFG];
                    end
                    A_LAPSE: tgl_q[T_LAPSE] <= ~tgl_q[T_LAPSE];
                    A_STAT:  if (wdata[0]) tgl_q[T_KICK] <= ~tgl_q[T_KICK];
                    A_RSEL:  sel_q <= masked_upd(sel_q, wdata);
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge pclk) begin
        if (prst) begin
            rdata <= '0;
        end else if (rd) begin
            case (a)
                A_CTRL:  rdata <= {{(DW-1){1'b0}}, cfg_q.en};
                A_PER:   rdata <= {cfg_q.per, {PER_LSB{1'b0}}};
                A_STAT:  rdata <= {{(DW-1){1'b0}}, pend_s};
                A_RSEL:  rdata <= {{(DW-SEL_W){1'b0}}, sel_q};
                default: rdata <= '0;
            endcase
        end
    end

    logic unused_wbits;
    assign unused_wbits = ^{wdata[PER_LSB-1:SEL_MSK+SEL_W], wdata[SEL_MSK-1:SEL_W]};

    assign cfg_o   = cfg_q;
    assign tgl_o   = tgl_q;
    assign route_o = sel_q;
endmodule

// File: rtl/wdt_osc_core.sv
module wdt_osc_core
    import wdt_pkg::*;
#(
    parameter int PRE_W = 20
) (
    input  logic            oclk,
    input  logic            orst,
    input  logic [NTGL-1:0] tgl_s,
    input  cfg_t            cfg_i,
    output logic            pend_o,
    output logic            rreq_o,
    output logic            en_o
);
    localparam logic [PRE_W-1:0] PRE_MAX = {PRE_W{1'b1}};

    logic [NTGL-1:0]  tgl_prev;
    logic [NTGL-1:0]  evt;
    cfg_t             cfg_q;
    logic [PRE_W-1:0] pre;
    logic [PER_W-1:0] cnt;
    logic             seen, pend, done, rreq;

    assign evt = tgl_s ^ tgl_prev;

    always_ff @(posedge oclk) begin
        if (orst) begin
            tgl_prev <= '0;
            cfg_q    <= '0;
            pre      <= '0;
            cnt      <= '0;
            seen     <= 1'b0;
            pend     <= 1'b0;
            done     <= 1'b0;
            rreq     <= 1'b0;
        end else begin
            tgl_prev <= tgl_s;
            rreq     <= 1'b0;
            if (evt[T_CFG]) cfg_q <= cfg_i;
            if (!cfg_q.en || evt[T_KICK]) begin
                pre  <= '0;
                cnt  <= '0;
                seen <= 1'b0;
                pend <= 1'b0;
            end else if (evt[T_LAPSE]) begin
                pre <= '0;
                cnt <= '0;
            end else if (!done) begin
                if (pre == PRE_MAX) begin
                    pre <= '0;
                    if (cnt == cfg_q.per) begin
                        cnt <= '0;
                        if (!seen) begin
                            seen <= 1'b1;
                            pend <= 1'b1;
                        end else begin
                            rreq <= 1'b1;
                            done <= 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end else begin
                    pre <= pre + 1'b1;
                end
            end
        end
    end

    assign pend_o = pend;
    assign rreq_o = rreq;
    assign en_o   = cfg_q.en;
endmodule

// File: rtl/wdt_dual_ovf.sv
module wdt_dual_ovf
    import wdt_pkg::*;
#(
    parameter int PRE_W = 20
) (
    input  logic        pclk,
    input  logic        prst,
    input  logic        oclk,
    input  logic        orst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        par_err_i,
    output logic        wdt_irq_o,
    output logic        perr_irq_o,
    output logic        sys_rst_req_o,
    output logic [2:0]  rst_route_o
);
    cfg_t            cfg;
    logic [NTGL-1:0] tgl_p, tgl_o;
    logic            pend_o, pend_p, core_en;

    wdt_bus_regs u_regs (
        .pclk(pclk), .prst(prst), .wr(bus_wr), .rd(bus_rd),
        .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
        .pend_s(pend_p), .par_err_i(par_err_i), .cfg_o(cfg),
        .tgl_o(tgl_p), .route_o(rst_route_o), .perr_o(perr_irq_o)
    );

    wdt_sync #(.W(NTGL), .STAGES(2)) u_to_osc (
        .clk(oclk), .rst(orst), .d(tgl_p), .q(tgl_o)
    );

    wdt_osc_core #(.PRE_W(PRE_W)) u_core (
        .oclk(oclk), .orst(orst), .tgl_s(tgl_o), .cfg_i(cfg),
        .pend_o(pend_o), .rreq_o(sys_rst_req_o), .en_o(core_en)
    );

    wdt_sync #(.W(1), .STAGES(2)) u_to_bus (
        .clk(pclk), .rst(prst), .d(pend_o), .q(pend_p)
    );

    assign wdt_irq_o = pend_o;
endmodule

// File: rtl/wdt_dual_ovf_chk.sv
module wdt_dual_ovf_chk (
    input logic        pclk,
    input logic        prst,
    input logic        oclk,
    input logic        orst,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [4:0]  bus_addr,
    input logic [31:0] bus_rdata,
    input logic        wdt_irq_o,
    input logic        sys_rst_req_o,
    input logic [2:0]  rst_route_o,
    input logic        en
);
    // R4
    rst_pulse_chk: assert property (@(posedge oclk) disable iff (orst)
        sys_rst_req_o |=> !sys_rst_req_o);

    // R4
    rst_after_irq_chk: assert property (@(posedge oclk) disable iff (orst)
        sys_rst_req_o |-> wdt_irq_o);

    // R7
    off_clears_irq_chk: assert property (@(posedge oclk) disable iff (orst)
        !en |=> !wdt_irq_o);

    // R3
    irq_needs_en_chk: assert property (@(posedge oclk) disable iff (orst)
        $rose(wdt_irq_o) |-> $past(en));

    // R9
    route_hold_chk: assert property (@(posedge pclk) disable iff (prst)
        !(bus_wr && bus_addr == 5'h10) |=> $stable(rst_route_o));

    // R2
    per_low_zero_chk: assert property (@(posedge pclk) disable iff (prst)
        (bus_rd && bus_addr == 5'h04) |=> (bus_rdata[19:0] == 20'h0));
endmodule

bind wdt_dual_ovf wdt_dual_ovf_chk u_chk (
    .pclk(pclk), .prst(prst), .oclk(oclk), .orst(orst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .wdt_irq_o(wdt_irq_o),
    .sys_rst_req_o(sys_rst_req_o), .rst_route_o(rst_route_o),
    .en(core_en)
);

// File: tb/sim_wdt_dual_ovf.sv
`timescale 1ns/1ps
module sim_wdt_dual_ovf;
    localparam int PRE_W = 2;
    localparam int PRE_N = 1 << PRE_W;

    logic        pclk = 0, oclk = 0, prst = 1, orst = 1;
    logic        bus_wr = 0, bus_rd = 0, par_err_i = 0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_irq_o, perr_irq_o, sys_rst_req_o;
    logic [2:0]  rst_route_o;

    int errors = 0, checks = 0, rst_cnt = 0;

    always #5 pclk = ~pclk;
    always #7 oclk = ~oclk;

    wdt_dual_ovf #(.PRE_W(PRE_W)) u0 (
        .pclk(pclk), .prst(prst), .oclk(oclk), .orst(orst),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .par_err_i(par_err_i),
        .wdt_irq_o(wdt_irq_o), .perr_irq_o(perr_irq_o),
        .sys_rst_req_o(sys_rst_req_o), .rst_route_o(rst_route_o)
    );

    always @(posedge oclk) begin
        #1;
        if (orst) rst_cnt = 0;
        else if (sys_rst_req_o) rst_cnt = rst_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge pclk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge pclk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge pclk);
        bus_rd = 1; bus_addr = a;
        @(negedge pclk);
        bus_rd = 0;
        d = bus_rdata;
    endtask

    task automatic ocyc(input int n);
        repeat (n) @(posedge oclk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge pclk);
        prst = 1; orst = 1;
        repeat (4) @(negedge pclk);
        prst = 0; orst = 0;
        ocyc(2);
    endtask

    task automatic wait_irq(input int lim, output int n);
        n = 0;
        while (!wdt_irq_o && n < lim) begin
            @(posedge oclk); #1; n++;
        end
    endtask

    task automatic wait_rst(input int lim, output int n);
        n = 0;
        while (!sys_rst_req_o && n < lim) begin
            @(posedge oclk); #1; n++;
        end
    endtask

    initial begin
        #3_000_000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int c1, c2, p;
        do_reset();

        // R1 reset state
        chk(!wdt_irq_o && !sys_rst_req_o && !perr_irq_o && rst_route_o == 0,
            "R1 outputs", {wdt_irq_o, sys_rst_req_o, perr_irq_o, rst_route_o}, 0);
        rd(5'h00, d); chk(d == 0, "R1 ctrl", d, 0);
        rd(5'h04, d); chk(d == 0, "R1 period", d, 0);
        rd(5'h0C, d); chk(d == 0, "R1 status", d, 0);
        rd(5'h10, d); chk(d == 0, "R1 route", d, 0);

        // R2 period register keeps [31:20]
        wr(5'h04, 32'hABCDE123); rd(5'h04, d);
        chk(d == 32'hABC00000, "R2 period mask", d, 32'hABC00000);
        wr(5'h04, 32'h000FFFFF); rd(5'h04, d);
        chk(d == 0, "R2 low bits ignored", d, 0);

        // R9 masked route writes: bit i from wdata[i] when wdata[16+i]
        wr(5'h10, 32'h0005_0007); rd(5'h10, d); chk(d == 5, "R9 mask 101", d, 5);
        wr(5'h10, 32'h0000_0002); rd(5'h10, d); chk(d == 5, "R9 no mask", d, 5);
        wr(5'h10, 32'h0002_0002); rd(5'h10, d); chk(d == 7, "R9 set bit1", d, 7);
        wr(5'h10, 32'h0001_0000); rd(5'h10, d); chk(d == 6, "R9 clr bit0", d, 6);
        chk(rst_route_o == 3'd6, "R9 route port", rst_route_o, 6);

        // R10 parity output one bus clock later
        @(negedge pclk); par_err_i = 1;
        chk(!perr_irq_o, "R10 before edge", perr_irq_o, 0);
        @(negedge pclk);
        chk(perr_irq_o, "R10 set", perr_irq_o, 1);
        par_err_i = 0;
        @(negedge pclk);
        chk(!perr_irq_o, "R10 clear", perr_irq_o, 0);

        // R3 / R4 / R8 sweep over N
        for (int n = 0; n < 8; n++) begin
            p = (n + 1) * PRE_N;
            do_reset();
            wr(5'h04, n << 20);
            wr(5'h00, 32'h1);
            wait_irq(p + 40, c1);
            chk(c1 >= p && c1 <= p + 5, "R3 first overflow", c1, p);
            wait_rst(p + 40, c2);
            chk(c2 == p, "R4 reset gap", c2, p);
            ocyc(1);
            chk(!sys_rst_req_o, "R4 single pulse", sys_rst_req_o, 0);
            ocyc(3 * p);
            chk(rst_cnt == 1, "R4 once only", rst_cnt, 1);
            rd(5'h0C, d);
            chk(d == 1, "R8 status pending", d, 1);
        end

        // R5 refresh through status register, N=3 -> 16 cycles
        p = 4 * PRE_N;
        do_reset();
        wr(5'h04, 3 << 20);
        wr(5'h00, 32'h1);
        wait_irq(p + 40, c1);
        wr(5'h0C, 32'h0);
        ocyc(3);
        chk(wdt_irq_o, "R5 zero write ignored", wdt_irq_o, 1);
        wr(5'h0C, 32'h1);
        ocyc(4);
        chk(!wdt_irq_o, "R5 pending cleared", wdt_irq_o, 0);
        rd(5'h0C, d);
        chk(d == 0, "R8 status cleared", d, 0);
        wait_irq(p + 40, c1);
        chk(wdt_irq_o && rst_cnt == 0, "R5 restart without reset", rst_cnt, 0);

        // R6 lapsed-time clear delays overflow
        do_reset();
        wr(5'h04, 3 << 20);
        wr(5'h00, 32'h1);
        ocyc(9);
        wr(5'h08, 32'h0);
        ocyc(13);
        chk(!wdt_irq_o, "R6 overflow delayed", wdt_irq_o, 0);
        wait_irq(60, c1);
        chk(wdt_irq_o && c1 >= 4 && c1 <= 20, "R6 later overflow", c1, 12);

        // R7 disable clears state
        p = 2 * PRE_N;
        do_reset();
        wr(5'h04, 1 << 20);
        wr(5'h00, 32'h1);
        wait_irq(p + 40, c1);
        wr(5'h00, 32'h0);
        ocyc(30);
        chk(!wdt_irq_o, "R7 irq cleared", wdt_irq_o, 0);
        chk(rst_cnt == 0, "R7 no reset", rst_cnt, 0);
        rd(5'h00, d);
        chk(d == 0, "R7 ctrl reads off", d, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule